// File: doc/BRIEF.md
# Edge-Compare Phase Detector with Dividers and Lock Monitor

This block is the digital heart of a frequency-synthesis loop. A fixed divider turns the crystal clock into a reference square wave at 1/512 of the crystal rate. A programmable divider turns the prescaled oscillator into a second square wave at 1/N of its input rate. A detector compares the falling edges of the two waves and drives pump-enable pulses toward an external charge pump. UP means the oscillator is early and DOWN means it is late. When neither pulse is active, the pump output sits in high impedance.

The whole block runs on the crystal clock. The prescaled oscillator arrives as a single-cycle enable, `vco_tick`, that is synchronous to that clock. Each tick advances the programmable divider by one count.

Control inputs do the following:
- force the pump into high impedance;
- pass a pump-current choice through to the analog side;
- put the block in test mode, which routes the divided oscillator onto a port pin and the reference onto a test pin.

A lock flag reports that the loop has stayed in phase over several consecutive comparisons.

Top module: `edge_phase_detector`

## Requirements
- R1: The reference wave is high while the crystal-cycle count since its last wrap is below 256 and low from 256 to 511, so its period is 512 cycles. Its falling event is the cycle in which the count equals 256. `ref_test` shows this wave while `ctl_test` is 1.
- R2: The divided oscillator wave is high while its tick count is below floor(N/2) and low from there up to N-1, so its period is N ticks. Its falling event is the cycle in which the count first equals floor(N/2). `p7_out` shows this wave while `ctl_test` is 1.
- R3: A requested ratio below 256 is used as 256. Ratios from 256 to 32767 are used as given.
- R4: A new `n_ratio` value takes effect only when the divider wraps from N-1 to 0. At reset, the value present during reset is taken.
- R5: When the oscillator falling event comes first, `pump_up` is 1 from the cycle after that event through the cycle in which the reference falling event occurs. The pulse is therefore as many cycles long as the distance between the two events.
- R6: When the reference falling event comes first, `pump_dn` is 1 from the cycle after it through the cycle of the oscillator falling event.
- R7: Events in the same cycle produce no pulse. `pump_up` and `pump_dn` are never 1 together. `pump_hiz` is 1 whenever neither is 1.
- R8: While `ctl_tristate` is 1, `pump_up` and `pump_dn` are 0 and `pump_hiz` is 1. The comparison continues underneath, so the outputs resume at once when the bit clears.
- R9: `pump_hicur` follows `ctl_hicur` in the same cycle.
- R10: While `ctl_test` is 0, `p7_out` equals `port_p7_bit` and `ref_test` is 0.
- R11: Each reference falling event ends one comparison. `lock` becomes 1 in the cycle after the 4th consecutive comparison in which no pump pulse lasted 2 or more cycles. Any comparison that contains such a pulse sets `lock` back to 0 in the cycle after it ends.
- R12: After reset, both counters are 0, `pump_up` and `pump_dn` are 0, `pump_hiz` is 1 and `lock` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_tick | input | 1 | One-cycle enable per prescaled oscillator period |
| n_ratio | input | 15 | Requested oscillator divide ratio |
| ctl_tristate | input | 1 | Force pump to high impedance |
| ctl_hicur | input | 1 | Pump-current select |
| ctl_test | input | 1 | Route divided signals to the port pins |
| port_p7_bit | input | 1 | Register value for the general-purpose port pin |
| pump_up | output | 1 | Source-current enable for the charge pump |
| pump_dn | output | 1 | Sink-current enable for the charge pump |
| pump_hiz | output | 1 | Pump high-impedance enable |
| pump_hicur | output | 1 | Pump-current select toward the pump |
| p7_out | output | 1 | Port pin: register bit or divided oscillator |
| ref_test | output | 1 | Reference wave in test mode, else 0 |
| lock | output | 1 | Phase-lock flag |

## Verification
Some properties are checked by assertions on every cycle:
- UP and DOWN never coexist.
- The tristate force always wins.
- Each pulse starts only after the matching falling event.
- The active ratio never drops below 256 and changes only at a divider wrap.
- The lock flag moves only right after a reference event.

Other behaviour can only be shown by the bench's scenarios, because it depends on the exact arithmetic of event times:
- pulse widths for leading and lagging phase;
- the growing UP widths of a ratio of 511;
- the five-cycle DOWN pulse after dropped ticks;
- the exact cycle in which lock rises;
- the clamped and reloaded ratios.

// File: rtl/epd_pkg.sv
// Package: shared constants and types for the edge-compare phase detector.
// Assumes: every submodule imports it; defaults describe a 4 MHz crystal setup.
package epd_pkg;

    localparam int REF_DIV_DEF  = 512;
    localparam int N_W_DEF      = 15;
    localparam int N_MIN_DEF    = 256;
    localparam int LOCK_CMP_DEF = 4;

    // Pump request held by the comparator between two falling events.
    typedef enum logic [1:0] {
        PUMP_OFF = 2'b00,
        PUMP_UP  = 2'b01,
        PUMP_DN  = 2'b10
    } pump_state_t;

endpackage

// File: rtl/epd_ref_div.sv
// Module: fixed reference divider.
// Divides the crystal clock by DIV. The output is high for the first DIV/2
// counts and low for the rest. The falling event is flagged in the cycle in
// which the count equals DIV/2.
// Assumes: DIV is even and at least 4.
module epd_ref_div #(
    parameter int DIV = epd_pkg::REF_DIV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_sig,
    output logic ref_fall
);

    localparam int CW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    // Free-running modulo-DIV count of crystal cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign ref_sig  = (cnt < CW'(HALF));
    assign ref_fall = (cnt == CW'(HALF));

endmodule

// File: rtl/epd_prog_div.sv
// Module: programmable oscillator divider.
// Counts oscillator ticks modulo the active ratio. The active ratio is
// reloaded from the request only at the wrap, so a running period is never
// cut short. Requests below N_MIN are raised to N_MIN. The falling event is
// a registered one-cycle pulse, present in the cycle in which the count first
// equals half the active ratio.
// Assumes: tick is synchronous to clk; N_MIN >= 4.
module epd_prog_div #(
    parameter int N_W   = epd_pkg::N_W_DEF,
    parameter int N_MIN = epd_pkg::N_MIN_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [N_W-1:0] n_req,
    output logic           div_sig,
    output logic           div_fall,
    output logic           div_wrap,
    output logic [N_W-1:0] n_act
);

    localparam logic [N_W-1:0] N_LOW = N_W'(N_MIN);

    logic [N_W-1:0] cnt;
    logic [N_W-1:0] cnt_inc;
    logic [N_W-1:0] n_half;
    logic [N_W-1:0] n_clamped;

    // Raise a too-small request to the lowest legal ratio.
    always_comb begin
        n_clamped = (n_req < N_LOW) ? N_LOW : n_req;
    end

    assign cnt_inc  = cnt + N_W'(1);
    assign n_half   = n_act >> 1;
    assign div_wrap = tick && (cnt == n_act - N_W'(1));

    // Tick counter, shadow ratio and registered falling-event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            n_act    <= n_clamped;
            div_fall <= 1'b0;
        end else begin
            div_fall <= tick && !div_wrap && (cnt_inc == n_half);
            if (div_wrap) begin
                cnt   <= '0;
                n_act <= n_clamped;
            end else if (tick) begin
                cnt <= cnt_inc;
            end
        end
    end

    assign div_sig = (cnt < n_half);

endmodule

// File: rtl/epd_compare.sv
// Module: falling-edge phase-frequency comparator.
// The oscillator event requests UP and the reference event requests DOWN.
// When both requests would be pending at once, both are cleared in the same
// cycle, so a pulse lasts exactly the distance between the two events.
// Assumes: each event input is a one-cycle pulse.
module epd_compare
    import epd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        div_evt,
    input  logic        ref_evt,
    output pump_state_t state
);

    logic want_up;
    logic want_dn;
    pump_state_t state_nx;

    // Merge held state with new events; cancel when both are wanted.
    always_comb begin
        want_up = (state == PUMP_UP) || div_evt;
        want_dn = (state == PUMP_DN) || ref_evt;
        if (want_up && want_dn) begin
            state_nx = PUMP_OFF;
        end else if (want_up) begin
            state_nx = PUMP_UP;
        end else if (want_dn) begin
            state_nx = PUMP_DN;
        end else begin
            state_nx = PUMP_OFF;
        end
    end

    // Pump request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PUMP_OFF;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/epd_lock_mon.sv
// Module: lock monitor.
// A comparison ends at each reference event. A comparison is clean when no
// pump pulse inside it lasted two or more cycles. The flag is set after
// LOCK_CMP clean comparisons in a row and clears at the end of any unclean one.
// Assumes: cmp_evt is a one-cycle pulse.
module epd_lock_mon #(
    parameter int LOCK_CMP = epd_pkg::LOCK_CMP_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic cmp_evt,
    output logic lock
);

    localparam int GW = $clog2(LOCK_CMP + 1);

    logic          prev_act;
    logic          wide_seen;
    logic          wide_now;
    logic [GW-1:0] good_cnt;

    assign wide_now = active && prev_act;

    // Track pulse length, sticky wide flag and the run of clean comparisons.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_act  <= 1'b0;
            wide_seen <= 1'b0;
            good_cnt  <= '0;
        end else begin
            prev_act <= active;
            if (cmp_evt) begin
                wide_seen <= 1'b0;
                if (wide_seen || wide_now) begin
                    good_cnt <= '0;
                end else if (good_cnt != GW'(LOCK_CMP)) begin
                    good_cnt <= good_cnt + GW'(1);
                end
            end else begin
                wide_seen <= wide_seen || wide_now;
            end
        end
    end

    assign lock = (good_cnt == GW'(LOCK_CMP));

endmodule

// File: rtl/edge_phase_detector.sv
// Module: edge-compare phase detector top level.
// Ties together the reference divider, the programmable oscillator divider,
// the comparator and the lock monitor. Applies the tristate force and the
// pump-current select, and routes the test signals.
// Assumes: a single crystal clock; the prescaled oscillator arrives as a
// synchronous one-cycle enable.
module edge_phase_detector
    import epd_pkg::*;
#(
    parameter int REF_DIV  = REF_DIV_DEF,
    parameter int N_W      = N_W_DEF,
    parameter int N_MIN    = N_MIN_DEF,
    parameter int LOCK_CMP = LOCK_CMP_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_tick,
    input  logic [N_W-1:0] n_ratio,
    input  logic           ctl_tristate,
    input  logic           ctl_hicur,
    input  logic           ctl_test,
    input  logic           port_p7_bit,
    output logic           pump_up,
    output logic           pump_dn,
    output logic           pump_hiz,
    output logic           pump_hicur,
    output logic           p7_out,
    output logic           ref_test,
    output logic           lock
);

    logic           ref_sig;
    logic           ref_fall;
    logic           div_sig;
    logic           div_fall;
    logic           div_wrap;
    logic [N_W-1:0] n_act;
    pump_state_t    cmp_st;
    logic           pulse_on;

    epd_ref_div #(.DIV(REF_DIV)) u_ref_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_sig  (ref_sig),
        .ref_fall (ref_fall)
    );

    epd_prog_div #(.N_W(N_W), .N_MIN(N_MIN)) u_prog_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (vco_tick),
        .n_req    (n_ratio),
        .div_sig  (div_sig),
        .div_fall (div_fall),
        .div_wrap (div_wrap),
        .n_act    (n_act)
    );

    epd_compare u_compare (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_evt (div_fall),
        .ref_evt (ref_fall),
        .state   (cmp_st)
    );

    assign pulse_on = (cmp_st != PUMP_OFF);

    epd_lock_mon #(.LOCK_CMP(LOCK_CMP)) u_lock_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (pulse_on),
        .cmp_evt (ref_fall),
        .lock    (lock)
    );

    // Pump drive: the tristate force overrides any pending request.
    always_comb begin
        pump_up  = (cmp_st == PUMP_UP) && !ctl_tristate;
        pump_dn  = (cmp_st == PUMP_DN) && !ctl_tristate;
        pump_hiz = ctl_tristate || !pulse_on;
    end

    // Port routing: test mode exposes both divided waves.
    always_comb begin
        pump_hicur = ctl_hicur;
        p7_out     = ctl_test ? div_sig : port_p7_bit;
        ref_test   = ctl_test && ref_sig;
    end

endmodule

// File: rtl/epd_checker.sv
// Module: property checker for edge_phase_detector, attached by bind.
// Assumes: its ports are wired to the top's ports and internal nets.
module epd_checker
    import epd_pkg::*;
#(
    parameter int N_W   = N_W_DEF,
    parameter int N_MIN = N_MIN_DEF
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pump_up,
    input logic           pump_dn,
    input logic           pump_hiz,
    input logic           ctl_tristate,
    input logic           ref_fall,
    input logic           div_fall,
    input logic           div_wrap,
    input logic [N_W-1:0] n_act,
    input pump_state_t    cmp_st,
    input logic           lock
);

    p_ref_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_fall |=> !ref_fall);

    p_ratio_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        n_act >= N_W'(N_MIN));

    p_ratio_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(n_act) |-> $past(div_wrap));

    p_up_after_osc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_st == PUMP_UP && $past(cmp_st) != PUMP_UP) |-> $past(div_fall));

    p_dn_after_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_st == PUMP_DN && $past(cmp_st) != PUMP_DN) |-> $past(ref_fall));

    p_no_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    p_idle_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_up && !pump_dn) |-> pump_hiz);

    p_force_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_tristate |-> (pump_hiz && !pump_up && !pump_dn));

    p_lock_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(ref_fall));

    p_lock_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> $past(ref_fall));

endmodule

bind edge_phase_detector epd_checker #(.N_W(N_W), .N_MIN(N_MIN)) u_epd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .pump_up      (pump_up),
    .pump_dn      (pump_dn),
    .pump_hiz     (pump_hiz),
    .ctl_tristate (ctl_tristate),
    .ref_fall     (ref_fall),
    .div_fall     (div_fall),
    .div_wrap     (div_wrap),
    .n_act        (n_act),
    .cmp_st       (cmp_st),
    .lock         (lock)
);

// File: tb/test_edge_phase_detector.sv
// Bench: scenario sweeps with a cycle-accurate arithmetic expectation.
module test_edge_phase_detector;

    localparam int CLK_PERIOD = 10;
    localparam int REF_DIV    = 512;
    localparam int HALF       = REF_DIV / 2;
    localparam int N_MIN      = 256;
    localparam int LOCK_CMP   = 4;
    localparam int NEVER      = 1 << 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vco_tick = 1'b0;
    logic [14:0] n_ratio = 15'd512;
    logic        ctl_tristate = 1'b0;
    logic        ctl_hicur = 1'b0;
    logic        ctl_test = 1'b0;
    logic        port_p7_bit = 1'b0;
    logic        pump_up, pump_dn, pump_hiz, pump_hicur, p7_out, ref_test, lock;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    edge_phase_detector i_edge_phase_detector (
        .clk          (clk),
        .rst_n        (rst_n),
        .vco_tick     (vco_tick),
        .n_ratio      (n_ratio),
        .ctl_tristate (ctl_tristate),
        .ctl_hicur    (ctl_hicur),
        .ctl_test     (ctl_test),
        .port_p7_bit  (port_p7_bit),
        .pump_up      (pump_up),
        .pump_dn      (pump_dn),
        .pump_hiz     (pump_hiz),
        .pump_hicur   (pump_hicur),
        .p7_out       (p7_out),
        .ref_test     (ref_test),
        .lock         (lock)
    );

    function automatic int nclamp(int n);
        return (n < N_MIN) ? N_MIN : n;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One scenario: reset, then a per-cycle comparison against the model.
    task automatic run_case(string tag, int n_a, int n_b, int sw_k, int mode,
                            int drop_lo, int drop_hi, int ts_lo, int ts_hi,
                            bit tst, bit p7b, bit hic_tgl, int len,
                            int win_lo, int win_hi, int exp_up, int exp_dn,
                            int lock_k);
        int rcnt, dcnt, nact, good, up_cnt, dn_cnt;
        bit dfall, up, dn, pact, wide;
        @(negedge clk);
        rst_n = 1'b0;
        n_ratio = 15'(n_a);
        ctl_test = tst;
        port_p7_bit = p7b;
        ctl_tristate = 1'b0;
        ctl_hicur = 1'b0;
        vco_tick = 1'b0;
        repeat (3) @(negedge clk);
        rcnt = 0; dcnt = 0; nact = nclamp(n_a); good = 0;
        dfall = 0; up = 0; dn = 0; pact = 0; wide = 0;
        up_cnt = 0; dn_cnt = 0;
        rst_n = 1'b1;
        chk("R12", {tag, " reset pump_up"}, int'(pump_up), 0);
        chk("R12", {tag, " reset pump_dn"}, int'(pump_dn), 0);
        chk("R12", {tag, " reset pump_hiz"}, int'(pump_hiz), 1);
        chk("R12", {tag, " reset lock"}, int'(lock), 0);
        for (int k = 0; k < len; k++) begin
            bit e_up, e_dn, ref_evt, div_evt, tk, su, sd, nu, ndn, nf, act, wn;
            int nd, nn;
            e_up = up && !ctl_tristate;
            e_dn = dn && !ctl_tristate;
            chk({tag, " R5"}, $sformatf("pump_up k=%0d", k), int'(pump_up), int'(e_up));
            chk({tag, " R6"}, $sformatf("pump_dn k=%0d", k), int'(pump_dn), int'(e_dn));
            chk({tag, " R7 R8"}, $sformatf("pump_hiz k=%0d", k), int'(pump_hiz),
                int'(ctl_tristate || (!up && !dn)));
            chk({tag, " R9"}, $sformatf("pump_hicur k=%0d", k), int'(pump_hicur), int'(ctl_hicur));
            chk({tag, ctl_test ? " R2" : " R10"}, $sformatf("p7_out k=%0d", k), int'(p7_out),
                ctl_test ? int'(dcnt < nact / 2) : int'(port_p7_bit));
            chk({tag, " R1"}, $sformatf("ref_test k=%0d", k), int'(ref_test),
                int'(ctl_test && (rcnt < HALF)));
            chk({tag, " R11"}, $sformatf("lock k=%0d", k), int'(lock), int'(good == LOCK_CMP));
            if (k == lock_k - 1) chk({tag, " R11"}, "lock one cycle early", int'(lock), 0);
            if (k == lock_k) chk({tag, " R11"}, "lock at its cycle", int'(lock), 1);
            if (k >= win_lo && k < win_hi) begin
                up_cnt += int'(pump_up);
                dn_cnt += int'(pump_dn);
            end
            // Inputs seen by the coming clock edge.
            n_ratio = 15'((k >= sw_k) ? n_b : n_a);
            tk = (mode == 1) ? (k % 2 == 0) : !(k >= drop_lo && k < drop_hi);
            vco_tick = tk;
            ctl_tristate = (k >= ts_lo && k < ts_hi);
            ctl_hicur = hic_tgl && ((k / 64) % 2 == 1);
            // Next state from the requirements.
            ref_evt = (rcnt == HALF);
            div_evt = dfall;
            nd = dcnt; nn = nact; nf = 0;
            if (tk) begin
                if (dcnt == nact - 1) begin
                    nd = 0;
                    nn = nclamp(int'(n_ratio));
                end else begin
                    nd = dcnt + 1;
                    nf = (nd == nact / 2);
                end
            end
            su = up || div_evt;
            sd = dn || ref_evt;
            nu = su && !sd;
            ndn = sd && !su;
            act = up || dn;
            wn = act && pact;
            if (ref_evt) begin
                good = (wide || wn) ? 0 : ((good < LOCK_CMP) ? good + 1 : good);
                wide = 0;
            end else begin
                wide = wide || wn;
            end
            pact = act;
            up = nu; dn = ndn; dfall = nf; dcnt = nd; nact = nn;
            rcnt = (rcnt == REF_DIV - 1) ? 0 : rcnt + 1;
            @(negedge clk);
        end
        chk({tag, " R5"}, "pump_up cycles in window", up_cnt, exp_up);
        chk({tag, " R6"}, "pump_dn cycles in window", dn_cnt, exp_dn);
    endtask

    initial begin : stimulus
        // Equal rates and phase: no pulses, lock at 256 + 3*512 + 1.
        run_case("R7 coincident", 512, 512, NEVER, 0, NEVER, NEVER, NEVER, NEVER,
                 1'b0, 1'b1, 1'b1, 2200, 0, 512, 0, 0, HALF + 3 * REF_DIV + 1);
        // Ratio 511: oscillator leads by 2 in the second period.
        run_case("R5 lead", 511, 511, NEVER, 0, NEVER, NEVER, 1500, 2100,
                 1'b1, 1'b0, 1'b0, 2600, 512, 1024, 2, 0, -1);
        // Ratio 513: reference leads by 1 in the second period.
        run_case("R6 lag", 513, 513, NEVER, 0, NEVER, NEVER, NEVER, NEVER,
                 1'b1, 1'b1, 1'b1, 2200, 512, 1024, 0, 1, -1);
        // Five dropped ticks give a five-cycle DOWN pulse each period.
        run_case("R6 drop", 512, 512, NEVER, 0, 1000, 1005, NEVER, NEVER,
                 1'b0, 1'b0, 1'b0, 2600, 1100, 1612, 0, 5, -1);
        // Ratio 100 runs as 256, with a tick on every other cycle.
        run_case("R3 clamp", 100, 100, NEVER, 1, NEVER, NEVER, NEVER, NEVER,
                 1'b1, 1'b0, 1'b0, 3000, 0, 0, 0, 0, -1);
        // Ratio change mid-period is held back until the wrap.
        run_case("R4 reload", 512, 520, 700, 0, NEVER, NEVER, NEVER, NEVER,
                 1'b1, 1'b0, 1'b1, 3000, 512, 1024, 0, 0, -1);
        // Largest ratio: DOWN from cycle 257 through 511 in the first period.
        run_case("R2 max", 32767, 32767, NEVER, 0, NEVER, NEVER, NEVER, NEVER,
                 1'b1, 1'b0, 1'b0, 1500, 0, 512, 0, 255, -1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule